// File: doc/BRIEF.md
# Host-Managed Memory Range Decoder Bank

This block turns a host physical address into an 8-bit downstream port number. It keeps a small bank of programmable decoder entries. Each entry has a range base, a range size, a control word and a list of eight interleave targets. Software loads the bank through a simple write port. A bank-wide capability code selects how many of the entries a lookup will scan.

A lookup is offered on `lk_valid`/`lk_addr` and is accepted while `lk_ready` is high. The block then scans entries one per clock, in ascending order, against the held address. The first entry whose range contains the address settles the lookup:

- If that entry is committed, the interleave index is computed from the address, the granularity and the ways. The port is then read out of the entry's target list.
- If that entry is not committed, the lookup ends as a miss.

A one-cycle `lk_done` pulse carries `lk_hit` and `lk_port`.

The controller has three states:

- `ST_IDLE`: waiting, `lk_ready` high. Transition *accept* goes to `ST_SCAN` on `lk_valid`.
- `ST_SCAN`: one entry per cycle. Transition *advance* stays in `ST_SCAN` with the next index. Transition *settle* goes to `ST_REPORT` on a range match or at the last scanned entry.
- `ST_REPORT`: drives the done pulse. Transition *release* returns to `ST_IDLE`.

Top module: `hdm_decode_bank`

## Requirements
- R1: After reset, `lk_ready` is 1 and `lk_done`, `lk_hit` and `lk_port` are 0. Every entry register and the capability code reset to zero.
- R2: While `cfg_wr_en` is high, a clock edge writes `cfg_wr_data` to one field of entry `cfg_wr_entry`. The field is chosen by `cfg_wr_field`:
  - 0: base low word
  - 1: base high word
  - 2: size low word
  - 3: size high word
  - 4: control word
  - 5: target list low word
  - 6: target list high word
  - 7: capability code in bits 3:0, regardless of the entry number
- R3: Only bits 31:28 of the base and size low words are kept; all other low-word bits are ignored. An entry's range matches when base ≤ address < base + size, with both bounds at 256 MiB resolution.
- R4: Entries are examined from index 0 upward. The first range match decides the result, even if later entries also match.
- R5: The control word holds the committed flag in bit 10. If the first matching entry has bit 10 clear, the lookup reports a miss and examines no later entry.
- R6: If no scanned entry matches, the lookup reports a miss. A miss always returns port 0.
- R7: The control word holds the granularity code in bits 3:0 and the ways code in bits 7:4. The target index is (address >> (8 + granularity code)) mod 2^w. Here w is the ways code, with any ways code above 3 treated as 3.
- R8: The target list is stored as eight byte lanes. Index i is byte i of the low word for i from 0 to 3, and byte i−4 of the high word for i from 4 to 7.
- R9: The number of entries scanned comes from the capability code:
  - code 0 selects one entry;
  - codes 1 to 4 select twice the code;
  - codes above 4 select one entry;
  - the result is never more than `NUM_ENTRIES`.
- R10: One entry is examined per clock. Suppose a lookup is accepted on edge E and decided at entry k, which is the matching entry or the last scanned entry. Then `lk_done` is high for exactly one cycle, following edge E+k+1. `lk_ready` is low from edge E until `lk_done` falls.
- R11: Whenever `lk_done` is low, `lk_hit` and `lk_port` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_entry | input | 4 | Entry number for the write |
| cfg_wr_field | input | 3 | Field select for the write |
| cfg_wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Host physical address to decode |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Result: committed entry matched |
| lk_port | output | 8 | Result: selected downstream port |

## Verification
The scan index, the held address and the result registers are all internal to the block, so the bench judges them through the result's value and timing.

- **Wrong scan index or entry count.** The done pulse arrives on the wrong cycle. Because the latency is fixed at k+1 cycles after acceptance, this is visible within one lookup.
- **Wrong range compare or priority.** The bench gives overlapping and boundary addresses, so this shows as a hit where a miss is due, or as a port taken from the wrong entry.
- **Wrong interleave arithmetic.** The bench sets a different byte in each target lane, so the returned port differs as soon as the selected lane is wrong.
- **Stuck controller state.** A missing done pulse or `lk_ready` stuck low stalls the scoreboard, and the bench reports the hang.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

    localparam int ADDR_W  = 64;
    localparam int BND_LSB = 28;
    localparam int BND_W   = ADDR_W - BND_LSB;
    localparam int PORT_W  = 8;
    localparam int TGT_N   = 8;
    localparam int SEL_W   = $clog2(TGT_N);
    localparam int CMT_BIT = 10;

    typedef enum logic [2:0] {
        FLD_BASE_LO = 3'd0,
        FLD_BASE_HI = 3'd1,
        FLD_SIZE_LO = 3'd2,
        FLD_SIZE_HI = 3'd3,
        FLD_CTRL    = 3'd4,
        FLD_TGT_LO  = 3'd5,
        FLD_TGT_HI  = 3'd6,
        FLD_CAP     = 3'd7
    } hdm_field_e;

    typedef struct packed {
        logic [BND_W-1:0]        base;
        logic [BND_W-1:0]        size;
        logic                    committed;
        logic [3:0]              ways;
        logic [3:0]              gran;
        logic [TGT_N*PORT_W-1:0] tlist;
    } hdm_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } scan_state_e;

    // Capability code to entry count: 0 and codes above 4 give one entry.
    function automatic logic [3:0] count_decode(input logic [3:0] code);
        logic [3:0] n;
        if (code == 4'd0 || code > 4'd4) begin
            n = 4'd1;
        end else begin
            n = {code[2:0], 1'b0};
        end
        return n;
    endfunction

endpackage

// File: rtl/hdm_regfile.sv
module hdm_regfile
    import hdm_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [3:0]                        wr_entry,
    input  logic [2:0]                        wr_field,
    input  logic [31:0]                       wr_data,
    output hdm_entry_t [NUM_ENTRIES-1:0]      entries_o,
    output logic [3:0]                        cap_code_o
);

    hdm_field_e fld;
    assign fld = hdm_field_e'(wr_field);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_entry == 4'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries_o[e] <= '0;
            end else if (sel) begin
                unique case (fld)
                    FLD_BASE_LO: entries_o[e].base[3:0]         <= wr_data[31:28];
                    FLD_BASE_HI: entries_o[e].base[BND_W-1:4]   <= wr_data;
                    FLD_SIZE_LO: entries_o[e].size[3:0]         <= wr_data[31:28];
                    FLD_SIZE_HI: entries_o[e].size[BND_W-1:4]   <= wr_data;
                    FLD_CTRL: begin
                        entries_o[e].committed <= wr_data[CMT_BIT];
                        entries_o[e].ways      <= wr_data[7:4];
                        entries_o[e].gran      <= wr_data[3:0];
                    end
                    FLD_TGT_LO:  entries_o[e].tlist[31:0]       <= wr_data;
                    FLD_TGT_HI:  entries_o[e].tlist[63:32]      <= wr_data;
                    FLD_CAP:     ;
                    default:     ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_code_o <= '0;
        end else if (wr_en && fld == FLD_CAP) begin
            cap_code_o <= wr_data[3:0];
        end
    end

endmodule

// File: rtl/hdm_entry_eval.sv
module hdm_entry_eval
    import hdm_pkg::*;
(
    input  hdm_entry_t          entry_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                match_o,
    output logic                committed_o,
    output logic [PORT_W-1:0]   port_o
);

    logic [BND_W-1:0]  addr_hi;
    logic [BND_W:0]    limit;
    logic [4:0]        shamt;
    logic [ADDR_W-1:0] chunk;
    logic [SEL_W-1:0]  mask;
    logic [SEL_W-1:0]  sel;

    always_comb begin
        addr_hi = addr_i[ADDR_W-1:BND_LSB];
        limit   = {1'b0, entry_i.base} + {1'b0, entry_i.size};
        match_o = (addr_hi >= entry_i.base) && ({1'b0, addr_hi} < limit);
        committed_o = entry_i.committed;

        shamt = 5'd8 + {1'b0, entry_i.gran};
        chunk = addr_i >> shamt;
        if (entry_i.ways >= 4'd3) begin
            mask = '1;
        end else begin
            mask = (SEL_W'(1) << entry_i.ways[1:0]) - SEL_W'(1);
        end
        sel    = chunk[SEL_W-1:0] & mask;
        port_o = entry_i.tlist[sel*PORT_W +: PORT_W];
    end

endmodule

// File: rtl/hdm_scan_fsm.sv
module hdm_scan_fsm
    import hdm_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CNT_W-1:0]     active_cnt,
    input  logic                 match_i,
    input  logic                 committed_i,
    input  logic [PORT_W-1:0]    port_i,
    output logic [ADDR_W-1:0]    scan_addr_o,
    output logic [IDX_W-1:0]     scan_idx_o,
    output logic                 req_ready,
    output logic                 done,
    output logic                 hit,
    output logic [PORT_W-1:0]    port
);

    scan_state_e       state, nxt;
    logic              last;
    logic              res_hit;
    logic [PORT_W-1:0] res_port;

    assign last = ((CNT_W'(scan_idx_o) + CNT_W'(1)) >= active_cnt) ||
                  (scan_idx_o == IDX_W'(NUM_ENTRIES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_SCAN;
            ST_SCAN:   if (match_i || last) nxt = ST_REPORT;
            ST_REPORT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_addr_o <= '0;
            scan_idx_o  <= '0;
            res_hit     <= 1'b0;
            res_port    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        scan_addr_o <= req_addr;
                        scan_idx_o  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (match_i) begin
                        res_hit  <= committed_i;
                        res_port <= committed_i ? port_i : '0;
                    end else if (last) begin
                        res_hit  <= 1'b0;
                        res_port <= '0;
                    end else begin
                        scan_idx_o <= scan_idx_o + IDX_W'(1);
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_REPORT);
        hit       = done && res_hit;
        port      = done ? res_port : '0;
    end

endmodule

// File: rtl/hdm_decode_bank.sv
module hdm_decode_bank
    import hdm_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr_en,
    input  logic [3:0]   cfg_wr_entry,
    input  logic [2:0]   cfg_wr_field,
    input  logic [31:0]  cfg_wr_data,
    input  logic         lk_valid,
    input  logic [63:0]  lk_addr,
    output logic         lk_ready,
    output logic         lk_done,
    output logic         lk_hit,
    output logic [7:0]   lk_port
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    hdm_entry_t [NUM_ENTRIES-1:0] entries;
    logic [3:0]                   cap_code;
    logic [3:0]                   dec_cnt;
    logic [CNT_W-1:0]             active_cnt;
    logic [ADDR_W-1:0]            scan_addr;
    logic [IDX_W-1:0]             scan_idx;
    hdm_entry_t                   cur_entry;
    logic                         cur_match;
    logic                         cur_commit;
    logic [PORT_W-1:0]            cur_port;

    hdm_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_entry   (cfg_wr_entry),
        .wr_field   (cfg_wr_field),
        .wr_data    (cfg_wr_data),
        .entries_o  (entries),
        .cap_code_o (cap_code)
    );

    always_comb begin
        dec_cnt = count_decode(cap_code);
        if (32'(dec_cnt) > NUM_ENTRIES) active_cnt = CNT_W'(NUM_ENTRIES);
        else                            active_cnt = CNT_W'(dec_cnt);
        cur_entry = entries[scan_idx];
    end

    hdm_entry_eval eval_i (
        .entry_i     (cur_entry),
        .addr_i      (scan_addr),
        .match_o     (cur_match),
        .committed_o (cur_commit),
        .port_o      (cur_port)
    );

    hdm_scan_fsm #(.NUM_ENTRIES(NUM_ENTRIES)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (lk_valid),
        .req_addr    (lk_addr),
        .active_cnt  (active_cnt),
        .match_i     (cur_match),
        .committed_i (cur_commit),
        .port_i      (cur_port),
        .scan_addr_o (scan_addr),
        .scan_idx_o  (scan_idx),
        .req_ready   (lk_ready),
        .done        (lk_done),
        .hit         (lk_hit),
        .port        (lk_port)
    );

endmodule

// File: rtl/hdm_decode_bank_chk.sv
module hdm_decode_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       lk_ready,
    input logic       lk_done,
    input logic       lk_hit,
    input logic [7:0] lk_port
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready);

    // R10
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> lk_ready);

    // R10
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> !lk_ready);

    // R11
    quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done |-> (!lk_hit && lk_port == 8'h00));

    // R6
    miss_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> lk_port == 8'h00);

endmodule

bind hdm_decode_bank hdm_decode_bank_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .lk_port  (lk_port)
);

// File: tb/hdm_decode_bank_tb_top.sv
module hdm_decode_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_entry = '0;
    logic [2:0]  cfg_wr_field = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        lk_ready;
    logic        lk_done;
    logic        lk_hit;
    logic [7:0]  lk_port;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int acc_cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       hit;
        logic [7:0] port;
        int         lat;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    hdm_decode_bank dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_entry (cfg_wr_entry),
        .cfg_wr_field (cfg_wr_field),
        .cfg_wr_data  (cfg_wr_data),
        .lk_valid     (lk_valid),
        .lk_addr      (lk_addr),
        .lk_ready     (lk_ready),
        .lk_done      (lk_done),
        .lk_hit       (lk_hit),
        .lk_port      (lk_port)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ent, input int fld, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en    = 1'b1;
        cfg_wr_entry = 4'(ent);
        cfg_wr_field = 3'(fld);
        cfg_wr_data  = data;
        @(negedge clk);
        cfg_wr_en    = 1'b0;
    endtask

    task automatic lookup(input logic [63:0] addr, input logic hit, input logic [7:0] port,
                          input int lat, input string tag);
        exp_t e;
        e.hit = hit; e.port = port; e.lat = lat; e.tag = tag;
        @(negedge clk);
        sb.push_back(e);
        lk_valid = 1'b1;
        lk_addr  = addr;
        @(negedge clk);
        acc_cyc  = cyc;
        lk_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops the expected result as each done pulse appears.
    always @(negedge clk) begin
        if (rst_n && lk_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(lk_hit == e.hit, {e.tag, " hit"}, lk_hit, e.hit);
                check(lk_port == e.port, {e.tag, " port"}, lk_port, e.port);
                check((cyc - acc_cyc) == e.lat, {e.tag, " R10 latency"}, cyc - acc_cyc, e.lat);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(lk_ready == 1'b1, "R1 ready", lk_ready, 1);
        check(lk_done == 1'b0, "R1 done", lk_done, 0);
        check(lk_hit == 1'b0, "R1 hit", lk_hit, 0);
        check(lk_port == 8'h00, "R1 port", lk_port, 0);

        // R2 programming: entry 0 at 4 GiB, 512 MiB; entry 1 at 16 GiB, 256 MiB
        wr(0, 1, 32'h1);
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h2000_0000);
        wr(0, 3, 32'h0);
        wr(0, 4, 32'h400);
        wr(0, 5, 32'h4433_2211);
        wr(1, 1, 32'h4);
        wr(1, 2, 32'h1000_0000);
        wr(1, 4, 32'h400);
        wr(1, 5, 32'h0000_0055);

        lookup(64'h1_0000_0040, 1'b1, 8'h11, 1, "R3 inside");
        lookup(64'h4_0000_0000, 1'b0, 8'h00, 1, "R9 code0 one entry");
        wr(0, 7, 32'h1);
        lookup(64'h4_0000_0000, 1'b1, 8'h55, 2, "R9 code1 two entries");
        lookup(64'h1_1FFF_FFFF, 1'b1, 8'h11, 1, "R3 last byte");
        lookup(64'h1_2000_0000, 1'b0, 8'h00, 2, "R3 R6 end bound");
        lookup(64'h0_FFFF_FFFF, 1'b0, 8'h00, 2, "R3 below base");
        wr(0, 0, 32'h0ABC_DEF0);
        lookup(64'h1_0000_0000, 1'b1, 8'h11, 1, "R3 low bits ignored");

        // R7 R8 interleave on entry 1
        wr(1, 5, 32'h4433_2211);
        wr(1, 6, 32'h8877_6655);
        wr(1, 4, 32'h422);
        lookup(64'h4_0000_0C05, 1'b1, 8'h44, 2, "R7 R8 four ways lane3");
        lookup(64'h4_0000_1000, 1'b1, 8'h11, 2, "R7 four ways wrap");
        wr(1, 4, 32'h432);
        lookup(64'h4_0000_1400, 1'b1, 8'h66, 2, "R8 eight ways high word");
        wr(1, 4, 32'h472);
        lookup(64'h4_0000_3400, 1'b1, 8'h66, 2, "R7 ways clamp");
        wr(1, 4, 32'h410);
        lookup(64'h4_0000_0100, 1'b1, 8'h22, 2, "R7 256B two ways");

        // R5 R4 overlap with entry 2
        wr(0, 7, 32'h2);
        wr(2, 1, 32'h4);
        wr(2, 2, 32'h1000_0000);
        wr(2, 4, 32'h400);
        wr(2, 5, 32'h0000_0099);
        wr(1, 4, 32'h010);
        lookup(64'h4_0000_0000, 1'b0, 8'h00, 2, "R5 uncommitted stops");
        wr(1, 4, 32'h400);
        lookup(64'h4_0000_0000, 1'b1, 8'h11, 2, "R4 first match wins");
        lookup(64'h8_0000_0000, 1'b0, 8'h00, 4, "R6 miss four entries");
        wr(0, 7, 32'h4);
        lookup(64'h8_0000_0000, 1'b0, 8'h00, 8, "R9 code4 eight entries");
        wr(0, 7, 32'h7);
        lookup(64'h4_0000_0000, 1'b0, 8'h00, 1, "R9 code7 one entry");

        @(negedge clk);
        // R11 outputs quiet between lookups
        check(lk_hit == 1'b0 && lk_port == 8'h00, "R11 idle outputs", {lk_hit, lk_port}, 0);
        check(lk_ready == 1'b1, "R10 ready after done", lk_ready, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule